// File: doc/BRIEF.md
# Host Memory-Bus Bridge Multiplexer

This block sits between a host processor's synchronous 16-bit external memory bus and an on-chip memory-mapped fabric. The host is always the bus master and the block is always the slave. Each host beat carries one 16-bit word, and the host holds its request until the block drops its wait line. The host gives a 26-bit word address, so the byte-select bit is not on the bus at all. The two most significant address bits pick one of four ports. Port 0 is built in. Ports 1 to 3 are routed out as select conduits for external bridge engines, and their wait and read data are returned to the host.

Port 0 is a single-access port that acts as a memory-mapped master. It moves a fixed 2-, 4- or 8-byte word per transaction and never issues a burst. For writes, it collects 16-bit beats in little-endian order into a word and issues the write only when the beat at the highest offset arrives. For reads, the beat at offset 0 issues the read and holds the host until the data returns. Later beats then return the buffered upper halves.

The top word of port 0's window is a reserved address. A host write to it does not reach the fabric. Instead it raises a system reset output for a fixed number of cycles.

Top module: `hostbus_bridge_mux`

## Requirements
- R1: While and just after `rst` is high, `host_wait`, `sys_rst`, `mm_read`, `mm_write` and every `link_sel` bit are 0.
- R2: With address bits [25:24] equal to 1, 2 or 3, `link_sel` bit 0, 1 or 2 respectively is high. In that case `link_addr` equals address bits [23:0], and `link_we` and `link_wdata` follow the host. `host_wait` and `host_rdata` come from the selected link, and the memory-mapped master stays idle.
- R3: A host write to word address 0x0FFFFFF completes with no wait. `sys_rst` goes high from the next cycle for exactly 16 cycles, and no memory-mapped write results.
- R4: With the default 4-byte size, a port 0 write beat at word offset k (address bits [0:0]) fills bits [16k+15:16k] of the write word. Exactly one `mm_write` is issued, after the beat at the highest offset is accepted. Earlier beats complete without wait.
- R5: `mm_addr` is the byte address of the transfer aligned down to the transfer size: the host word address with its offset bits cleared, shifted left by one.
- R6: A port 0 read beat at offset 0 waits while one `mm_read` completes and then returns bits [15:0]. A read beat at a higher offset k returns bits [16k+15:16k] of the last read word with no wait and no new `mm_read`.
- R7: While `mm_read` or `mm_write` is high and `mm_waitrequest` is high, the request, `mm_addr` and `mm_wdata` stay unchanged into the next cycle.
- R8: A reserved-address write while `sys_rst` is already high restarts the 16-cycle count from that write.
- R9: A host read of the reserved address is an ordinary port 0 read and leaves `sys_rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host beat present |
| host_we | input | 1 | Host beat is a write |
| host_addr | input | 26 | Host word address |
| host_wdata | input | 16 | Host write word |
| host_rdata | output | 16 | Read word returned to host |
| host_wait | output | 1 | Host must hold the current beat |
| sys_rst | output | 1 | Reset pulse for the rest of the fabric |
| link_sel | output | 3 | One select per external bridge port (ports 1..3) |
| link_we | output | 1 | Write flag toward external ports |
| link_addr | output | 24 | Word address within the port window |
| link_wdata | output | 16 | Write word toward external ports |
| link_rdata | input | 48 | Read words from ports 1..3, port 1 in bits [15:0] |
| link_wait | input | 3 | Wait lines from ports 1..3 |
| mm_addr | output | 25 | Memory-mapped byte address |
| mm_read | output | 1 | Memory-mapped read request |
| mm_write | output | 1 | Memory-mapped write request |
| mm_wdata | output | 32 | Memory-mapped write word |
| mm_readdata | input | 32 | Memory-mapped read word |
| mm_waitrequest | input | 1 | Slave stall |

## Verification
If the beat buffers or offset decoding go wrong, the host sees a swapped or stale half-word on the very beat that reads it. On the fabric side, a wrong `mm_wdata` or `mm_addr` appears in the single write the transaction produces. If the port-0 sequencer loses its place, the offset-0 read either never waits or stays stuck with `host_wait` high, so the next read shows it. A wrong reset counter shows as a `sys_rst` pulse that is too short, too long or not reloaded, which the cycle-by-cycle reference count catches on the first cycle it differs.

// File: rtl/hbm_pkg.sv
package hbm_pkg;

    localparam int unsigned SEL_W     = 2;
    localparam int unsigned NUM_PORTS = 1 << SEL_W;
    localparam int unsigned NUM_LINKS = NUM_PORTS - 1;

    typedef enum logic [1:0] {
        PIO_IDLE = 2'd0,
        PIO_BUSY = 2'd1,
        PIO_DONE = 2'd2
    } pio_state_e;

    typedef struct packed {
        logic [SEL_W-1:0] port;
        logic             reset_hit;
        logic             local_sel;
    } route_t;

    // A write fires at the highest offset, a read at offset zero.
    function automatic logic starts_xfer(input logic we, input logic at_first, input logic at_last);
        return we ? at_last : at_first;
    endfunction

endpackage

// File: rtl/hbm_addr_decode.sv
module hbm_addr_decode
    import hbm_pkg::*;
#(
    parameter int HOST_AW = 26,
    localparam int PORT_AW = HOST_AW - SEL_W
) (
    input  logic               valid,
    input  logic               we,
    input  logic [HOST_AW-1:0] addr,
    output route_t             route,
    output logic [NUM_LINKS-1:0] link_sel
);

    logic [SEL_W-1:0] port;
    logic             top_word;

    assign port     = addr[HOST_AW-1 -: SEL_W];
    assign top_word = &addr[PORT_AW-1:0];

    always_comb begin
        route.port      = port;
        route.reset_hit = valid && we && (port == '0) && top_word;
        route.local_sel = valid && (port == '0) && !route.reset_hit;
    end

    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
        assign link_sel[i] = valid && (port == SEL_W'(i + 1));
    end

endmodule

// File: rtl/hbm_reset_pulse.sv
module hbm_reset_pulse #(
    parameter int RST_CYCLES = 16,
    localparam int CW = $clog2(RST_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger,
    output logic pulse
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (trigger) begin
            cnt_q <= CW'(RST_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pulse = (cnt_q != '0);

    // R3: the pulse starts the cycle after the reserved write
    a_r3_pulse_starts: assert property (@(posedge clk) disable iff (rst)
        trigger |=> pulse) else $error("reset pulse did not start");

    // R8: a new trigger reloads the full count
    a_r8_reload: assert property (@(posedge clk) disable iff (rst)
        trigger |=> (cnt_q == CW'(RST_CYCLES))) else $error("reset count not reloaded");

endmodule

// File: rtl/hbm_single_port.sv
module hbm_single_port
    import hbm_pkg::*;
#(
    parameter int PORT_AW    = 24,
    parameter int XFER_BYTES = 4,
    localparam int BEATS = XFER_BYTES / 2,
    localparam int LB    = $clog2(BEATS),
    localparam int IDXW  = (LB > 0) ? LB : 1,
    localparam int MM_DW = 8 * XFER_BYTES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel,
    input  logic               we,
    input  logic [PORT_AW-1:0] word_addr,
    input  logic [15:0]        wdata,
    output logic [15:0]        rdata,
    output logic               hold,
    output logic [PORT_AW:0]   mm_addr,
    output logic               mm_read,
    output logic               mm_write,
    output logic [MM_DW-1:0]   mm_wdata,
    input  logic [MM_DW-1:0]   mm_readdata,
    input  logic               mm_waitrequest
);

    localparam logic [IDXW-1:0] LAST = IDXW'(BEATS - 1);

    pio_state_e                 state_q;
    logic [BEATS-1:0][15:0]     wbuf_q;
    logic [BEATS-1:0][15:0]     rbuf_q;
    logic [PORT_AW-1:0]         base_q;
    logic                       we_q;
    logic [IDXW-1:0]            idx;
    logic [PORT_AW-1:0]         base;
    logic                       start;

    if (LB > 0) begin : g_idx
        assign idx = word_addr[IDXW-1:0];
    end else begin : g_noidx
        assign idx = '0;
    end

    assign base  = word_addr & ~PORT_AW'(BEATS - 1);
    assign start = sel && (state_q == PIO_IDLE) && starts_xfer(we, idx == '0, idx == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PIO_IDLE;
            wbuf_q  <= '0;
            rbuf_q  <= '0;
            base_q  <= '0;
            we_q    <= 1'b0;
        end else begin
            case (state_q)
                PIO_IDLE: begin
                    if (sel && we) wbuf_q[idx] <= wdata;
                    if (start) begin
                        base_q  <= base;
                        we_q    <= we;
                        state_q <= PIO_BUSY;
                    end
                end
                PIO_BUSY: begin
                    if (!mm_waitrequest) begin
                        if (!we_q) rbuf_q <= mm_readdata;
                        state_q <= PIO_DONE;
                    end
                end
                default: state_q <= PIO_IDLE;
            endcase
        end
    end

    assign hold     = start || (state_q == PIO_BUSY);
    assign rdata    = rbuf_q[idx];
    assign mm_addr  = {base_q, 1'b0};
    assign mm_read  = (state_q == PIO_BUSY) && !we_q;
    assign mm_write = (state_q == PIO_BUSY) && we_q;
    assign mm_wdata = wbuf_q;

    // R7: a stalled request is held unchanged
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
        ((mm_read || mm_write) && mm_waitrequest) |=>
        ($stable(mm_addr) && $stable(mm_wdata) && $stable(mm_read) && $stable(mm_write)))
        else $error("request changed under waitrequest");

    // R4: a write is issued only after the last-offset beat
    a_r4_write_after_last: assert property (@(posedge clk) disable iff (rst)
        $rose(mm_write) |-> $past(sel && we && (idx == LAST)))
        else $error("write issued before last beat");

    // R6: one read per transaction, dropped once accepted
    a_r6_single_read: assert property (@(posedge clk) disable iff (rst)
        (mm_read && !mm_waitrequest) |=> !mm_read)
        else $error("read repeated");

endmodule

// File: rtl/hostbus_bridge_mux.sv
module hostbus_bridge_mux
    import hbm_pkg::*;
#(
    parameter int HOST_AW    = 26,
    parameter int XFER_BYTES = 4,
    parameter int RST_CYCLES = 16,
    localparam int PORT_AW = HOST_AW - SEL_W,
    localparam int MM_DW   = 8 * XFER_BYTES
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    host_valid,
    input  logic                    host_we,
    input  logic [HOST_AW-1:0]      host_addr,
    input  logic [15:0]             host_wdata,
    output logic [15:0]             host_rdata,
    output logic                    host_wait,
    output logic                    sys_rst,
    output logic [NUM_LINKS-1:0]    link_sel,
    output logic                    link_we,
    output logic [PORT_AW-1:0]      link_addr,
    output logic [15:0]             link_wdata,
    input  logic [16*NUM_LINKS-1:0] link_rdata,
    input  logic [NUM_LINKS-1:0]    link_wait,
    output logic [PORT_AW:0]        mm_addr,
    output logic                    mm_read,
    output logic                    mm_write,
    output logic [MM_DW-1:0]        mm_wdata,
    input  logic [MM_DW-1:0]        mm_readdata,
    input  logic                    mm_waitrequest
);

    route_t      route;
    logic [15:0] pio_rdata;
    logic        pio_hold;

    hbm_addr_decode #(.HOST_AW(HOST_AW)) u_decode (
        .valid    (host_valid),
        .we       (host_we),
        .addr     (host_addr),
        .route    (route),
        .link_sel (link_sel)
    );

    hbm_reset_pulse #(.RST_CYCLES(RST_CYCLES)) u_rstgen (
        .clk     (clk),
        .rst     (rst),
        .trigger (route.reset_hit),
        .pulse   (sys_rst)
    );

    hbm_single_port #(.PORT_AW(PORT_AW), .XFER_BYTES(XFER_BYTES)) u_pio (
        .clk            (clk),
        .rst            (rst),
        .sel            (route.local_sel),
        .we             (host_we),
        .word_addr      (host_addr[PORT_AW-1:0]),
        .wdata          (host_wdata),
        .rdata          (pio_rdata),
        .hold           (pio_hold),
        .mm_addr        (mm_addr),
        .mm_read        (mm_read),
        .mm_write       (mm_write),
        .mm_wdata       (mm_wdata),
        .mm_readdata    (mm_readdata),
        .mm_waitrequest (mm_waitrequest)
    );

    assign link_we    = host_we;
    assign link_addr  = host_addr[PORT_AW-1:0];
    assign link_wdata = host_wdata;

    always_comb begin
        host_wait  = route.local_sel && pio_hold;
        host_rdata = pio_rdata;
        for (int i = 0; i < NUM_LINKS; i++) begin
            if (link_sel[i]) begin
                host_wait  = link_wait[i];
                host_rdata = link_rdata[16*i +: 16];
            end
        end
    end

    // R2: a port-0 access never selects an external link
    a_r2_local_no_link: assert property (@(posedge clk) disable iff (rst)
        (host_valid && (host_addr[HOST_AW-1 -: SEL_W] == '0)) |-> (link_sel == '0))
        else $error("link selected for port 0");

    // R3: the reserved write completes at once and is not forwarded
    a_r3_reserved_nowait: assert property (@(posedge clk) disable iff (rst)
        route.reset_hit |-> (!host_wait && !mm_write))
        else $error("reserved write stalled or forwarded");

endmodule

// File: tb/hostbus_bridge_mux_tb.sv
module hostbus_bridge_mux_tb;

    localparam logic [25:0] RES = 26'h0FFFFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hv = 1'b0, hwe = 1'b0;
    logic [25:0] ha = '0;
    logic [15:0] hwd = '0;
    logic [15:0] host_rdata;
    logic        host_wait, sys_rst;
    logic [2:0]  link_sel, link_wait;
    logic        link_we;
    logic [23:0] link_addr;
    logic [15:0] link_wdata;
    logic [47:0] link_rdata;
    logic [24:0] mm_addr;
    logic        mm_read, mm_write, mm_waitrequest;
    logic [31:0] mm_wdata, mm_readdata;

    int total = 0, fails = 0;
    int ws = 0, lws = 0;
    int wcnt = 0, lcnt = 0;
    int nreads = 0, nwrites = 0;
    int rc = 0, hi = 0;
    logic [24:0] last_wa;
    logic [31:0] last_wd;
    logic [23:0] lw_addr;
    logic [15:0] lw_data;
    logic [2:0]  lw_port;
    logic [31:0] mem [0:255];
    logic        pend = 1'b0;
    logic [24:0] p_addr;
    logic [31:0] p_wdata;
    logic        p_rd, p_wr;

    always #5 clk = ~clk;

    hostbus_bridge_mux u_dut (
        .clk(clk), .rst(rst), .host_valid(hv), .host_we(hwe), .host_addr(ha),
        .host_wdata(hwd), .host_rdata(host_rdata), .host_wait(host_wait),
        .sys_rst(sys_rst), .link_sel(link_sel), .link_we(link_we),
        .link_addr(link_addr), .link_wdata(link_wdata), .link_rdata(link_rdata),
        .link_wait(link_wait), .mm_addr(mm_addr), .mm_read(mm_read),
        .mm_write(mm_write), .mm_wdata(mm_wdata), .mm_readdata(mm_readdata),
        .mm_waitrequest(mm_waitrequest)
    );

    assign mm_waitrequest = (mm_read || mm_write) && (wcnt < ws);
    assign mm_readdata    = mem[mm_addr[9:2]];
    assign link_wait      = link_sel & {3{lcnt < lws}};
    assign link_rdata     = {link_addr[15:0] ^ 16'h3000, link_addr[15:0] ^ 16'h2000,
                             link_addr[15:0] ^ 16'h1000};

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural slaves and reset-pulse reference, updated on each edge
    always @(posedge clk) begin
        if (rst) rc = 0;
        else if (hv && hwe && ha == RES) rc = 16;
        else if (rc > 0) rc = rc - 1;
        if ((mm_read || mm_write) && !mm_waitrequest) begin
            if (mm_write) begin
                mem[mm_addr[9:2]] <= mm_wdata;
                nwrites++;
                last_wa = mm_addr;
                last_wd = mm_wdata;
            end else begin
                nreads++;
            end
            wcnt <= 0;
        end else if (mm_read || mm_write) begin
            wcnt <= wcnt + 1;
        end
        if (|link_sel && !host_wait) begin
            lcnt <= 0;
            if (link_we) begin
                lw_addr = link_addr;
                lw_data = link_wdata;
                lw_port = link_sel;
            end
        end else if (|link_sel) begin
            lcnt <= lcnt + 1;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            logic [2:0] e_ls;
            e_ls = (hv && ha[25:24] != 2'd0) ? 3'(3'b001 << (ha[25:24] - 2'd1)) : 3'b000;
            chk(sys_rst == (rc != 0), "R3", "sys_rst vs reference count", 32'(sys_rst), 32'(rc != 0));
            chk(link_sel == e_ls, "R2", "link_sel", 32'(link_sel), 32'(e_ls));
            if (hv && ha[25:24] != 2'd0)
                chk(link_addr == ha[23:0], "R2", "link_addr", 32'(link_addr), 32'(ha[23:0]));
            if (pend)
                chk(mm_addr == p_addr && mm_wdata == p_wdata && mm_read == p_rd && mm_write == p_wr,
                    "R7", "stalled request changed", 32'(mm_addr), 32'(p_addr));
            if (sys_rst) hi++;
        end
        pend    = !rst && (mm_read || mm_write) && mm_waitrequest;
        p_addr  = mm_addr;
        p_wdata = mm_wdata;
        p_rd    = mm_read;
        p_wr    = mm_write;
    end

    task automatic beat(input logic we, input logic [25:0] a, input logic [15:0] d,
                        output logic [15:0] rd, output int waits);
        @(negedge clk);
        hv = 1'b1; hwe = we; ha = a; hwd = d;
        waits = 0;
        forever begin
            #1;
            if (!host_wait) break;
            @(negedge clk);
            waits++;
        end
        rd = host_rdata;
        @(posedge clk);
        #1;
        hv = 1'b0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        int w, r0, w0;
        repeat (3) @(negedge clk);
        #2;
        // R1: outputs quiet during reset
        chk(!host_wait && !sys_rst && !mm_read && !mm_write && link_sel == 0, "R1",
            "outputs in reset", {host_wait, sys_rst, mm_read, mm_write, link_sel}, 0);
        @(negedge clk); rst = 1'b0;
        #2;
        chk(!host_wait && !sys_rst && !mm_read && !mm_write && link_sel == 0, "R1",
            "outputs after reset", {host_wait, sys_rst, mm_read, mm_write, link_sel}, 0);

        // R4, R5: two-beat write with slave stalls
        ws = 2;
        beat(1'b1, 26'h10, 16'h1111, rd, w);
        chk(w == 0, "R4", "first write beat wait", w, 0);
        chk(nwrites == 0, "R4", "write issued early", nwrites, 0);
        beat(1'b1, 26'h11, 16'h2222, rd, w);
        chk(w > 0, "R4", "last write beat waits", w, 1);
        chk(nwrites == 1, "R4", "write count", nwrites, 1);
        chk(last_wd == 32'h22221111, "R4", "assembled write word", last_wd, 32'h22221111);
        chk(last_wa == 25'h20, "R5", "write byte address", 32'(last_wa), 32'h20);

        // R5: odd-offset pair maps to the aligned address
        ws = 0;
        beat(1'b1, 26'h22, 16'h5A5A, rd, w);
        beat(1'b1, 26'h23, 16'hA5A5, rd, w);
        chk(last_wa == 25'h44, "R5", "aligned byte address", 32'(last_wa), 32'h44);
        chk(last_wd == 32'hA5A55A5A, "R4", "second write word", last_wd, 32'hA5A55A5A);

        // R6: read back with slave stall
        ws = 1;
        r0 = nreads;
        beat(1'b0, 26'h10, 16'h0, rd, w);
        chk(rd == 16'h1111, "R6", "read low half", rd, 16'h1111);
        chk(w > 0, "R6", "offset-0 read waits", w, 1);
        beat(1'b0, 26'h11, 16'h0, rd, w);
        chk(rd == 16'h2222, "R6", "read upper half", rd, 16'h2222);
        chk(w == 0, "R6", "buffered beat wait", w, 0);
        chk(nreads == r0 + 1, "R6", "one read per transaction", nreads, r0 + 1);

        // R6: second word, no slave stall
        ws = 0;
        beat(1'b1, 26'h80, 16'hCAFE, rd, w);
        beat(1'b1, 26'h81, 16'hBEEF, rd, w);
        beat(1'b0, 26'h80, 16'h0, rd, w);
        chk(rd == 16'hCAFE, "R6", "read low half 2", rd, 16'hCAFE);
        beat(1'b0, 26'h81, 16'h0, rd, w);
        chk(rd == 16'hBEEF, "R6", "read upper half 2", rd, 16'hBEEF);

        // R9: reading the reserved address is an ordinary read
        hi = 0;
        r0 = nreads;
        beat(1'b0, RES, 16'h0, rd, w);
        repeat (4) @(negedge clk);
        chk(rd == 16'hBEEF, "R9", "reserved read data", rd, 16'hBEEF);
        chk(hi == 0, "R9", "no reset on read", hi, 0);
        chk(nreads == r0, "R9", "no new fabric read", nreads, r0);

        // R3: reserved write pulse
        hi = 0;
        w0 = nwrites;
        beat(1'b1, RES, 16'hFFFF, rd, w);
        chk(w == 0, "R3", "reserved write wait", w, 0);
        repeat (20) @(negedge clk);
        #3;
        chk(hi == 16, "R3", "pulse length", hi, 16);
        chk(nwrites == w0, "R3", "reserved write not forwarded", nwrites, w0);

        // R8: retrigger during the pulse
        hi = 0;
        beat(1'b1, RES, 16'h0, rd, w);
        repeat (5) @(negedge clk);
        beat(1'b1, RES, 16'h0, rd, w);
        repeat (24) @(negedge clk);
        #3;
        chk(hi == 22, "R8", "reloaded pulse length", hi, 22);

        // R2: external links
        r0 = nreads;
        w0 = nwrites;
        lws = 2;
        beat(1'b0, {2'b10, 24'h001234}, 16'h0, rd, w);
        chk(rd == 16'h3234, "R2", "link 2 read data", rd, 16'h3234);
        chk(w == 2, "R2", "link wait passed to host", w, 2);
        lws = 0;
        beat(1'b1, {2'b11, 24'h00ABCD}, 16'h7777, rd, w);
        chk(w == 0, "R2", "link 3 write wait", w, 0);
        chk(lw_port == 3'b100 && lw_addr == 24'h00ABCD && lw_data == 16'h7777, "R2",
            "link 3 write", {lw_port, lw_addr[11:0], lw_data}, {3'b100, 12'hBCD, 16'h7777});
        beat(1'b0, {2'b01, 24'h000055}, 16'h0, rd, w);
        chk(rd == 16'h1055, "R2", "link 1 read data", rd, 16'h1055);
        chk(nreads == r0 && nwrites == w0, "R2", "fabric idle on links", nreads + nwrites, r0 + w0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule